// File: doc/BRIEF.md
# Stimulus Frame Program Sequencer

This block runs a small stored program that drives a frame transmitter for bus stimulus work. Software loads instruction words into an internal program memory while the sequencer is stopped. It then issues a start pulse, and the sequencer executes one instruction per clock from address 0. The program can request transmission of a numbered frame definition, hold until the transmitter reports completion, wait a number of microseconds, keep loop counters in four 16-bit variables, and branch on equality or on a bitwise mask test. An armed send waits for an external trigger before it requests the frame.

Each instruction word is 32 bits wide:
- bits [31:28] hold the opcode. The codes are 0 stop, 1 send, 2 jump, 3 wait, 4 load variable, 5 decrement variable, 6 branch-if-equal, 7 branch-if-mask and 8 armed send.
- bits [27:26] select the variable.
- bits [25:18] hold the frame index or the branch target. The branch target is the low address bits.
- bits [17:16] are reserved and must be zero.
- bits [15:0] hold the parameter.

The transmitter itself and the program loader are outside this block.

Top module: `cangen_sequencer`

## Requirements
- R1: After reset, `busy`, `tx_start` and `tx_frame` are all zero.
- R2: A `go` pulse while idle starts execution at address 0 and raises `busy`. Opcode 0 returns the block to idle. A `halt` pulse returns it to idle on the next clock from any state, including while it waits.
- R3: A program-memory write is accepted only while `busy` is low. A write attempted while `busy` is high leaves the memory unchanged.
- R4: Opcode 1 (send) produces a `tx_start` pulse exactly one clock long, with `tx_frame` equal to bits [25:18]. The sequencer does not move to the next instruction until `tx_done` is seen.
- R5: Opcode 2 (jump) continues execution at the address in bits [25:18].
- R6: Opcode 3 (wait) pauses for parameter × TICK_DIV clocks beyond the time a zero-length wait takes. A parameter of 0 adds no waiting.
- R7: Opcode 4 loads the selected variable with the parameter, and opcode 5 subtracts one from it. Opcode 6 jumps to bits [25:18] when the selected variable equals the parameter; otherwise it falls through. The four variables are independent of each other.
- R8: Opcode 7 jumps when the bitwise AND of the selected variable and the parameter is nonzero; otherwise it falls through.
- R9: Opcode 8 (armed send) raises no `tx_start` until `trig_in` is sampled high while waiting. It then sends the frame in bits [25:18] and waits for `tx_done` as a send does.
- R10: Decrementing a variable that holds 0 gives 0xFFFF.
- R11: An opcode above 8, or a word with nonzero reserved bits [17:16], stops execution just as opcode 0 does, and requests no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_we | input | 1 | Program-memory write strobe |
| pm_waddr | input | $clog2(PROG_DEPTH) | Program-memory write address |
| pm_wdata | input | 32 | Instruction word to store |
| go | input | 1 | Start pulse, acted on only while idle |
| halt | input | 1 | Stop pulse |
| trig_in | input | 1 | External trigger level for armed sends |
| tx_done | input | 1 | Transmitter completion pulse |
| tx_start | output | 1 | One-clock frame request |
| tx_frame | output | 8 | Index of the frame requested |
| busy | output | 1 | High while a program runs |

## Verification
The assertions check several properties on every clock:
- each frame request is a single clock long, and no request appears while the block is idle or while an armed send sees no trigger;
- a pending send holds its address until completion;
- a halt empties the block on the next clock;
- an equal-compare branch lands on its target;
- a locked memory word stays unchanged;
- a loaded variable holds its value;
- the microsecond prescaler holds the remaining count between ticks.

Only the directed scenarios can show the whole-program behaviour: the sequence of frames requested by loops, the mask branch and the decrement wrap, the exact extra length of a wait, and the fact that a blocked write is really absent on the next run.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int OP_W   = 4;
  localparam int VSEL_W = 2;
  localparam int FLD_W  = 8;
  localparam int RSV_W  = 2;
  localparam int PRM_W  = 16;
  localparam int INSN_W = OP_W + VSEL_W + FLD_W + RSV_W + PRM_W;
  localparam int NVAR   = 1 << VSEL_W;

  typedef enum logic [OP_W-1:0] {
    OP_END    = 4'd0,
    OP_SEND   = 4'd1,
    OP_GOTO   = 4'd2,
    OP_DELAY  = 4'd3,
    OP_SETVAR = 4'd4,
    OP_DECVAR = 4'd5,
    OP_IF     = 4'd6,
    OP_TEST   = 4'd7,
    OP_ARM    = 4'd8
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [VSEL_W-1:0] vsel;
    logic [FLD_W-1:0]  fld;
    logic [RSV_W-1:0]  rsv;
    logic [PRM_W-1:0]  prm;
  } insn_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_WTX, ST_WTRIG, ST_WDLY
  } seq_st_e;
endpackage

// File: rtl/cgs_prog_mem.sv
module cgs_prog_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic         wr_en;

  assign wr_en = we_i & ~lock_i;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R3: a write attempted while locked leaves the word unchanged
  assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && lock_i) |=> (mem_q[$past(waddr_i)] == $past(mem_q[waddr_i])));
endmodule

// File: rtl/cgs_var_file.sv
module cgs_var_file #(
  parameter int NVAR = 4,
  parameter int VW   = 16,
  localparam int IW  = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [VW-1:0] wdata_i,
  output logic [VW-1:0] rdata_o
);
  logic [VW-1:0] var_q [NVAR];

  for (genvar g = 0; g < NVAR; g++) begin : g_var
    logic hit;
    assign hit = we_i && (idx_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   var_q[g] <= '0;
      else if (hit) var_q[g] <= wdata_i;
    end
  end

  assign rdata_o = var_q[idx_i];

  // R7: a loaded variable holds the value written
  assert_var_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (var_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/cgs_us_timer.sv
module cgs_us_timer #(
  parameter int TICK_DIV = 50,
  parameter int CW       = 16,
  localparam int PW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          en;
  logic          wrap;

  assign wrap = (pre_q == LAST);
  assign en   = clr_i | load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (clr_i) begin
      cnt_d = '0;
      pre_d = '0;
    end else if (load_i) begin
      cnt_d = val_i;
      pre_d = '0;
    end else if (cnt_q != '0) begin
      if (wrap) begin
        pre_d = '0;
        cnt_d = cnt_q - CW'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign done_o = (cnt_q == CW'(1)) && wrap;

  // R6: the remaining count only moves on a prescaler wrap
  assert_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && cnt_q != '0 && !wrap) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cangen_sequencer.sv
module cangen_sequencer
  import cgs_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int TICK_DIV   = 50,
  localparam int AW        = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pm_we,
  input  logic [AW-1:0]     pm_waddr,
  input  logic [INSN_W-1:0] pm_wdata,
  input  logic              go,
  input  logic              halt,
  input  logic              trig_in,
  input  logic              tx_done,
  output logic              tx_start,
  output logic [FLD_W-1:0]  tx_frame,
  output logic              busy
);
  seq_st_e           st_q, st_d;
  logic [AW-1:0]     pc_q, pc_d, pc_inc, tgt;
  logic              start_q, start_d;
  logic [FLD_W-1:0]  frame_q, frame_d;
  logic [INSN_W-1:0] mem_rdata;
  insn_t             ir;
  logic              legal;
  logic              var_we;
  logic [PRM_W-1:0]  var_wd, var_rd;
  logic              tmr_load, tmr_done;

  cgs_prog_mem #(.DEPTH(PROG_DEPTH), .W(INSN_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .we_i(pm_we), .lock_i(busy),
    .waddr_i(pm_waddr), .wdata_i(pm_wdata), .raddr_i(pc_q), .rdata_o(mem_rdata)
  );

  assign ir     = insn_t'(mem_rdata);
  assign legal  = (ir.rsv == '0);
  assign pc_inc = pc_q + AW'(1);
  assign tgt    = ir.fld[AW-1:0];

  cgs_var_file #(.NVAR(NVAR), .VW(PRM_W)) i_vars (
    .clk(clk), .rst_n(rst_n), .we_i(var_we), .idx_i(ir.vsel),
    .wdata_i(var_wd), .rdata_o(var_rd)
  );

  cgs_us_timer #(.TICK_DIV(TICK_DIV), .CW(PRM_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(halt), .load_i(tmr_load),
    .val_i(ir.prm), .done_o(tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    start_d  = 1'b0;
    frame_d  = frame_q;
    tmr_load = 1'b0;
    var_we   = 1'b0;
    var_wd   = ir.prm;
    case (st_q)
      ST_IDLE: if (go) begin
        st_d = ST_EXEC;
        pc_d = '0;
      end
      ST_EXEC: begin
        if (!legal) st_d = ST_IDLE;
        else case (ir.op)
          OP_SEND: begin
            start_d = 1'b1;
            frame_d = ir.fld;
            st_d    = ST_WTX;
          end
          OP_ARM:  st_d = ST_WTRIG;
          OP_GOTO: pc_d = tgt;
          OP_DELAY: begin
            if (ir.prm == '0) pc_d = pc_inc;
            else begin
              tmr_load = 1'b1;
              st_d     = ST_WDLY;
            end
          end
          OP_SETVAR: begin
            var_we = 1'b1;
            pc_d   = pc_inc;
          end
          OP_DECVAR: begin
            var_we = 1'b1;
            var_wd = var_rd - PRM_W'(1);
            pc_d   = pc_inc;
          end
          OP_IF:   pc_d = (var_rd == ir.prm) ? tgt : pc_inc;
          OP_TEST: pc_d = ((var_rd & ir.prm) != '0) ? tgt : pc_inc;
          default: st_d = ST_IDLE;
        endcase
      end
      ST_WTX: if (tx_done) begin
        pc_d = pc_inc;
        st_d = ST_EXEC;
      end
      ST_WTRIG: if (trig_in) begin
        start_d = 1'b1;
        frame_d = ir.fld;
        st_d    = ST_WTX;
      end
      ST_WDLY: if (tmr_done) begin
        pc_d = pc_inc;
        st_d = ST_EXEC;
      end
      default: st_d = ST_IDLE;
    endcase
    if (halt) begin
      st_d     = ST_IDLE;
      start_d  = 1'b0;
      var_we   = 1'b0;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      start_q <= 1'b0;
      frame_q <= '0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      start_q <= start_d;
      if (start_d) frame_q <= frame_d;
    end
  end

  assign tx_start = start_q;
  assign tx_frame = frame_q;
  assign busy     = (st_q != ST_IDLE);

  // R4: requests last one clock and only occur while running
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> busy);
  // R4: a pending send keeps its address until completion
  assert_wait_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WTX && !tx_done && !halt) |=> (busy && pc_q == $past(pc_q)));
  // R2: halt empties the block, stop opcode ends the run
  assert_halt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy && !tx_start));
  assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && ir.op == OP_END) |=> !busy);
  // R7: an equal compare lands on the target address
  assert_if_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && legal && ir.op == OP_IF && var_rd == ir.prm && !halt)
    |=> (pc_q == $past(tgt)));
  // R9: no request while an armed send sees no trigger
  assert_arm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WTRIG && !trig_in) |=> !tx_start);
endmodule

// File: tb/test_cangen_sequencer.sv
module test_cangen_sequencer;
  localparam int DEPTH = 64;
  localparam int TDIV  = 10;
  localparam int AW    = $clog2(DEPTH);
  localparam int DL    = 4;

  logic clk, rst_n, pm_we, go, halt, trig_in, tx_done, tx_start, busy;
  logic [AW-1:0] pm_waddr;
  logic [31:0]   pm_wdata;
  logic [7:0]    tx_frame;
  logic resp_done, man_done, resp_en;

  int checks, errors, n_sent, cyc, long_cnt;
  logic [7:0] log_frame [32];
  int         log_cyc [32];
  logic       prev_start;
  int         rcnt;

  assign tx_done = resp_done | man_done;

  cangen_sequencer #(.PROG_DEPTH(DEPTH), .TICK_DIV(TDIV)) i_cangen_sequencer (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_waddr(pm_waddr),
    .pm_wdata(pm_wdata), .go(go), .halt(halt), .trig_in(trig_in),
    .tx_done(tx_done), .tx_start(tx_start), .tx_frame(tx_frame), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      if (n_sent < 32) begin
        log_frame[n_sent] = tx_frame;
        log_cyc[n_sent]   = cyc;
      end
      n_sent++;
      if (prev_start) long_cnt++;
    end
    prev_start = tx_start;
    resp_done <= 1'b0;
    if (tx_start && resp_en) rcnt = DL;
    else if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) resp_done <= 1'b1;
    end
  end

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [1:0] v,
                                      input logic [7:0] f, input logic [15:0] p);
    return {op, v, f, 2'b00, p};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] w);
    @(negedge clk);
    pm_we = 1'b1; pm_waddr = AW'(a); pm_wdata = w;
    @(negedge clk);
    pm_we = 1'b0;
  endtask

  task automatic run();
    @(negedge clk);
    n_sent = 0; long_cnt = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !tx_start && tx_frame == 8'h00, "R1", {busy, tx_start, tx_frame}, 0);
  endtask

  task automatic t_send_goto();
    put(0, enc(1, 0, 8'h12, 0)); put(1, enc(2, 0, 8'd3, 0));
    put(2, enc(1, 0, 8'h99, 0)); put(3, enc(1, 0, 8'hAB, 0)); put(4, enc(0, 0, 0, 0));
    run(); wait_idle();
    check(n_sent == 2, "R5 count", n_sent, 2);
    check(log_frame[0] == 8'h12, "R4 frame", log_frame[0], 8'h12);
    check(log_frame[1] == 8'hAB, "R5 target", log_frame[1], 8'hAB);
    check(long_cnt == 0, "R4 pulse width", long_cnt, 0);
    check(!busy, "R2 end", busy, 0);
  endtask

  task automatic t_wait_done_halt();
    resp_en = 1'b0;
    put(0, enc(1, 0, 8'h21, 0)); put(1, enc(1, 0, 8'h22, 0)); put(2, enc(0, 0, 0, 0));
    run();
    repeat (30) @(negedge clk);
    check(n_sent == 1 && busy, "R4 holds for done", n_sent, 1);
    man_done = 1'b1; @(negedge clk); man_done = 1'b0;
    repeat (3) @(negedge clk);
    check(n_sent == 2 && log_frame[1] == 8'h22, "R4 advance on done", log_frame[1], 8'h22);
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    check(!busy, "R2 halt", busy, 0);
    repeat (5) @(negedge clk);
    check(n_sent == 2 && !busy, "R2 stays stopped", n_sent, 2);
    resp_en = 1'b1;
  endtask

  task automatic t_delay();
    int d0, d4;
    put(0, enc(1, 0, 8'h01, 0)); put(1, enc(3, 0, 0, 16'd0));
    put(2, enc(1, 0, 8'h02, 0)); put(3, enc(0, 0, 0, 0));
    run(); wait_idle();
    d0 = log_cyc[1] - log_cyc[0];
    put(1, enc(3, 0, 0, 16'd4));
    run(); wait_idle();
    d4 = log_cyc[1] - log_cyc[0];
    check(n_sent == 2, "R6 sends", n_sent, 2);
    check(d4 - d0 == 4 * TDIV, "R6 extra delay", d4 - d0, 4 * TDIV);
  endtask

  task automatic t_loop();
    put(0, enc(4, 3, 0, 16'd9));   put(1, enc(4, 0, 0, 16'd3));
    put(2, enc(1, 0, 8'h05, 0));   put(3, enc(5, 0, 0, 0));
    put(4, enc(6, 0, 8'd6, 16'd0)); put(5, enc(2, 0, 8'd2, 0));
    put(6, enc(6, 3, 8'd8, 16'd9)); put(7, enc(0, 0, 0, 0));
    put(8, enc(1, 0, 8'h77, 0));   put(9, enc(0, 0, 0, 0));
    run(); wait_idle();
    check(n_sent == 4, "R7 loop count", n_sent, 4);
    check(log_frame[2] == 8'h05, "R7 loop frame", log_frame[2], 8'h05);
    check(log_frame[3] == 8'h77, "R7 independent var", log_frame[3], 8'h77);
  endtask

  task automatic t_test();
    put(0, enc(4, 1, 0, 16'h000A)); put(1, enc(7, 1, 8'd3, 16'h0004));
    put(2, enc(1, 0, 8'h11, 0));    put(3, enc(7, 1, 8'd5, 16'h0002));
    put(4, enc(1, 0, 8'h22, 0));    put(5, enc(1, 0, 8'h33, 0));
    put(6, enc(0, 0, 0, 0));
    run(); wait_idle();
    check(n_sent == 2, "R8 count", n_sent, 2);
    check(log_frame[0] == 8'h11, "R8 no jump", log_frame[0], 8'h11);
    check(log_frame[1] == 8'h33, "R8 jump", log_frame[1], 8'h33);
  endtask

  task automatic t_wrap();
    put(0, enc(4, 2, 0, 16'd0)); put(1, enc(5, 2, 0, 0));
    put(2, enc(6, 2, 8'd4, 16'hFFFF)); put(3, enc(0, 0, 0, 0));
    put(4, enc(1, 0, 8'h44, 0)); put(5, enc(0, 0, 0, 0));
    run(); wait_idle();
    check(n_sent == 1 && log_frame[0] == 8'h44, "R10 wrap", log_frame[0], 8'h44);
  endtask

  task automatic t_arm();
    put(0, enc(8, 0, 8'h66, 0)); put(1, enc(0, 0, 0, 0));
    run();
    repeat (20) @(negedge clk);
    check(n_sent == 0 && busy, "R9 waits", n_sent, 0);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    repeat (2) @(negedge clk);
    check(n_sent == 1 && log_frame[0] == 8'h66, "R9 fires", log_frame[0], 8'h66);
    wait_idle();
    check(!busy, "R9 completes", busy, 0);
  endtask

  task automatic t_lock();
    put(0, enc(3, 0, 0, 16'd2)); put(1, enc(1, 0, 8'h50, 0)); put(2, enc(0, 0, 0, 0));
    run();
    put(1, enc(1, 0, 8'h5F, 0));
    wait_idle();
    check(n_sent == 1 && log_frame[0] == 8'h50, "R3 blocked", log_frame[0], 8'h50);
    put(1, enc(1, 0, 8'h5F, 0));
    run(); wait_idle();
    check(n_sent == 1 && log_frame[0] == 8'h5F, "R3 accepted", log_frame[0], 8'h5F);
  endtask

  task automatic t_illegal();
    put(0, enc(4'hF, 0, 0, 0)); put(1, enc(1, 0, 8'h01, 0)); put(2, enc(0, 0, 0, 0));
    run(); repeat (5) @(negedge clk);
    check(n_sent == 0 && !busy, "R11 bad opcode", n_sent, 0);
    put(0, enc(1, 0, 8'h02, 0) | 32'h0001_0000);
    run(); repeat (5) @(negedge clk);
    check(n_sent == 0 && !busy, "R11 reserved bits", n_sent, 0);
  endtask

  initial begin
    checks = 0; errors = 0; n_sent = 0; cyc = 0; long_cnt = 0; rcnt = 0;
    prev_start = 1'b0;
    rst_n = 1'b0; pm_we = 1'b0; pm_waddr = '0; pm_wdata = '0;
    go = 1'b0; halt = 1'b0; trig_in = 1'b0; man_done = 1'b0;
    resp_done = 1'b0; resp_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send_goto();
    t_wait_done_halt();
    t_delay();
    t_loop();
    t_test();
    t_wrap();
    t_arm();
    t_lock();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule